// File: doc/BRIEF.md
# Dual-Mask Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines and presents them to a processor as two active-high request outputs: a normal request and a fast request. Each source line is ORed with a bit of a software-writable injection latch to form a shared raw pending vector. Two independent enable masks select which raw bits reach each output. Software reads a masked status word to find out which enabled sources are pending. A value of zero means nothing is pending.

Software reaches the block over a plain register bus made of an address, a write enable, write data and combinational read data. Enables and injection bits change only through write-1-to-set and write-1-to-clear addresses. Software can therefore flip a single bit without a read-modify-write sequence. Both request outputs are registered. Sources are level-sensitive, so a handler must either mask the source or remove its cause before the request drops.

Top module: `dual_mask_intc`

## Requirements
- R1: After reset both enable masks and the injection latch are zero, and irqOut and fiqOut are low.
- R2: A write to address 0x08 sets every normal-request enable bit whose write-data bit is 1 and leaves the other enable bits unchanged. A read of 0x08 returns the normal-request enable mask.
- R3: A write to address 0x0C clears every normal-request enable bit whose write-data bit is 1 and leaves the other enable bits unchanged. A read of 0x0C returns zero.
- R4: Address 0x28 is the fast-request enable set port, and a read of it returns the fast mask. Address 0x2C is the fast-request clear port, and a read of it returns zero. The fast mask and the normal mask never affect each other.
- R5: A read of 0x04 or of 0x24 returns the raw vector, whose bit n is source input n ORed with injection bit n.
- R6: A read of 0x00 returns the raw vector ANDed with the normal mask. A read of 0x20 returns the raw vector ANDed with the fast mask.
- R7: A write to 0x10 sets the injection bits whose write-data bit is 1. A write to 0x14 clears the injection bits whose write-data bit is 1. A read of 0x10 returns the injection latch.
- R8: irqOut is the OR of all bits of the normal masked status, and fiqOut is the OR of all bits of the fast masked status. Both are registered, so they reflect a write or an input change at the clock edge after it.
- R9: A request stays high for as long as an enabled source stays high. It falls one edge after that source is masked or goes low.
- R10: Reads of 0x14, of 0x2C and of unmapped addresses return zero. Writes to the status addresses, the raw addresses or unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register byte address |
| wrEn | input | 1 | Write strobe, one write per cycle |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for addr |
| srcIn | input | 32 | Level-sensitive source lines, source n on bit n |
| irqOut | output | 1 | Registered normal interrupt request |
| fiqOut | output | 1 | Registered fast interrupt request |

## Verification
The enable ports are exercised with sparse and overlapping bit patterns, so a set or clear that disturbs bits outside its write word shows up as a changed mask. The raw and masked views are read with a source pattern and an injection pattern that overlap only in part, and with different normal and fast masks. This separates an OR from a replacement and shows that each mask applies only to its own view. The requests are sampled both right after the enabling edge and one edge later, which catches a missing or extra register stage. Level behaviour is shown by holding the request through several idle cycles and then removing it by masking and, separately, by dropping the source.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam logic [7:0] OFF_IRQ_STAT = 8'h00;
  localparam logic [7:0] OFF_IRQ_RAW  = 8'h04;
  localparam logic [7:0] OFF_IRQ_ESET = 8'h08;
  localparam logic [7:0] OFF_IRQ_ECLR = 8'h0C;
  localparam logic [7:0] OFF_SW_SET   = 8'h10;
  localparam logic [7:0] OFF_SW_CLR   = 8'h14;
  localparam logic [7:0] OFF_FIQ_STAT = 8'h20;
  localparam logic [7:0] OFF_FIQ_RAW  = 8'h24;
  localparam logic [7:0] OFF_FIQ_ESET = 8'h28;
  localparam logic [7:0] OFF_FIQ_ECLR = 8'h2C;

  typedef struct packed {
    logic irqEnSet;
    logic irqEnClr;
    logic fiqEnSet;
    logic fiqEnClr;
    logic swSet;
    logic swClr;
  } wrStrobe_t;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_IRQ_STAT,
    SEL_RAW,
    SEL_IRQ_EN,
    SEL_SW,
    SEL_FIQ_STAT,
    SEL_FIQ_EN
  } rdSel_t;

endpackage

// File: rtl/intc_setclr_reg.sv
module intc_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         setStb,
  input  logic         clrStb,
  input  logic [W-1:0] bitsIn,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      q <= '0;
    end else if (setStb) begin
      q <= q | bitsIn;
    end else if (clrStb) begin
      q <= q & ~bitsIn;
    end
  end

  // R2 R4 R7: set port turns on every written 1
  set_bits_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    setStb |=> ((q & $past(bitsIn)) == $past(bitsIn)));

  // R3 R4 R7: clear port turns off every written 1
  clr_bits_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrStb && !setStb) |=> ((q & $past(bitsIn)) == '0));

  // R2 R3: bits written as 0 keep their value
  other_bits_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setStb || clrStb) |=> ((q & ~$past(bitsIn)) == ($past(q) & ~$past(bitsIn))));

  // R10: no strobe leaves the register alone
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!setStb && !clrStb) |=> $stable(q));

endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output wrStrobe_t         stb,
  output rdSel_t            rdSel
);

  always_comb begin
    stb = '0;
    if (wrEn) begin
      stb.irqEnSet = (addr == ADDR_W'(OFF_IRQ_ESET));
      stb.irqEnClr = (addr == ADDR_W'(OFF_IRQ_ECLR));
      stb.fiqEnSet = (addr == ADDR_W'(OFF_FIQ_ESET));
      stb.fiqEnClr = (addr == ADDR_W'(OFF_FIQ_ECLR));
      stb.swSet    = (addr == ADDR_W'(OFF_SW_SET));
      stb.swClr    = (addr == ADDR_W'(OFF_SW_CLR));
    end
  end

  always_comb begin
    if (addr == ADDR_W'(OFF_IRQ_STAT))      rdSel = SEL_IRQ_STAT;
    else if (addr == ADDR_W'(OFF_IRQ_RAW))  rdSel = SEL_RAW;
    else if (addr == ADDR_W'(OFF_FIQ_RAW))  rdSel = SEL_RAW;
    else if (addr == ADDR_W'(OFF_IRQ_ESET)) rdSel = SEL_IRQ_EN;
    else if (addr == ADDR_W'(OFF_SW_SET))   rdSel = SEL_SW;
    else if (addr == ADDR_W'(OFF_FIQ_STAT)) rdSel = SEL_FIQ_STAT;
    else if (addr == ADDR_W'(OFF_FIQ_ESET)) rdSel = SEL_FIQ_EN;
    else                                    rdSel = SEL_ZERO;
  end

  // R10: at most one register is written per cycle
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // R10: no strobe without a bus write
  no_wr_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (stb == '0));

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         stb,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              fiqOut
);

  logic [NUM_SRC-1:0] wrBits;
  logic [NUM_SRC-1:0] irqEnQ;
  logic [NUM_SRC-1:0] fiqEnQ;
  logic [NUM_SRC-1:0] swQ;
  logic [NUM_SRC-1:0] rawVec;
  logic [NUM_SRC-1:0] irqStat;
  logic [NUM_SRC-1:0] fiqStat;

  assign wrBits = wrData[NUM_SRC-1:0];

  intc_setclr_reg #(.W(NUM_SRC)) i_irqEn (
    .clk(clk), .rstN(rstN), .setStb(stb.irqEnSet), .clrStb(stb.irqEnClr),
    .bitsIn(wrBits), .q(irqEnQ));

  intc_setclr_reg #(.W(NUM_SRC)) i_fiqEn (
    .clk(clk), .rstN(rstN), .setStb(stb.fiqEnSet), .clrStb(stb.fiqEnClr),
    .bitsIn(wrBits), .q(fiqEnQ));

  intc_setclr_reg #(.W(NUM_SRC)) i_swLatch (
    .clk(clk), .rstN(rstN), .setStb(stb.swSet), .clrStb(stb.swClr),
    .bitsIn(wrBits), .q(swQ));

  assign rawVec  = srcIn | swQ;
  assign irqStat = rawVec & irqEnQ;
  assign fiqStat = rawVec & fiqEnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqOut <= 1'b0;
      fiqOut <= 1'b0;
    end else begin
      irqOut <= |irqStat;
      fiqOut <= |fiqStat;
    end
  end

  function automatic logic [DATA_W-1:0] widen(input logic [NUM_SRC-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[NUM_SRC-1:0] = v;
    return r;
  endfunction

  always_comb begin
    case (rdSel)
      SEL_IRQ_STAT: rdData = widen(irqStat);
      SEL_RAW:      rdData = widen(rawVec);
      SEL_IRQ_EN:   rdData = widen(irqEnQ);
      SEL_SW:       rdData = widen(swQ);
      SEL_FIQ_STAT: rdData = widen(fiqStat);
      SEL_FIQ_EN:   rdData = widen(fiqEnQ);
      default:      rdData = '0;
    endcase
  end

  // R8: an empty normal mask gives no normal request on the next edge
  irq_mask_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnQ == '0) |=> !irqOut);

  // R8: an empty fast mask gives no fast request on the next edge
  fiq_mask_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fiqEnQ == '0) |=> !fiqOut);

  // R9: an enabled high source keeps the normal request up
  irq_level_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((srcIn & irqEnQ) != '0) |=> irqOut);

  // R9: an enabled high source keeps the fast request up
  fiq_level_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((srcIn & fiqEnQ) != '0) |=> fiqOut);

  // R7: an injected bit that is enabled raises the request
  sw_inject_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((swQ & (irqEnQ | fiqEnQ)) != '0) |=> (irqOut || fiqOut));

endmodule

// File: rtl/dual_mask_intc.sv
module dual_mask_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut,
  output logic               fiqOut
);

  wrStrobe_t stb;
  rdSel_t    rdSel;

  intc_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
    .stb(stb), .rdSel(rdSel));

  intc_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .wrData(wrData),
    .srcIn(srcIn), .rdData(rdData), .irqOut(irqOut), .fiqOut(fiqOut));

  // R1: requests are low in the cycle after reset
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!irqOut && !fiqOut));

endmodule

// File: tb/test_dual_mask_intc.sv
module test_dual_mask_intc;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  addr;
  logic        wrEn;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic [31:0] srcIn;
  logic        irqOut;
  logic        fiqOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_mask_intc i_dual_mask_intc (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .srcIn(srcIn), .irqOut(irqOut), .fiqOut(fiqOut));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic readChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRead(a, v);
    chk(req, v, exp);
  endtask

  task automatic nextEdge();
    @(posedge clk);
    #1;
  endtask

  task automatic clearAll();
    busWrite(8'h0C, 32'hFFFF_FFFF);
    busWrite(8'h2C, 32'hFFFF_FFFF);
    busWrite(8'h14, 32'hFFFF_FFFF);
    @(negedge clk);
    srcIn = '0;
    nextEdge();
  endtask

  task automatic testReset();
    srcIn = 32'hFFFF_FFFF;
    rstN = 1'b0;
    repeat (3) nextEdge();
    chk("R1 irqOut in reset", {31'b0, irqOut}, 32'h0);
    chk("R1 fiqOut in reset", {31'b0, fiqOut}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    nextEdge();
    readChk("R1 irq mask", 8'h08, 32'h0);
    readChk("R1 fiq mask", 8'h28, 32'h0);
    readChk("R1 inject latch", 8'h10, 32'h0);
    chk("R1 irqOut after reset", {31'b0, irqOut}, 32'h0);
    chk("R1 fiqOut after reset", {31'b0, fiqOut}, 32'h0);
    @(negedge clk);
    srcIn = '0;
  endtask

  task automatic testIrqEnable();
    busWrite(8'h08, 32'h0000_00F0);
    readChk("R2 set", 8'h08, 32'h0000_00F0);
    busWrite(8'h08, 32'h0000_0F00);
    readChk("R2 set keeps others", 8'h08, 32'h0000_0FF0);
    busWrite(8'h0C, 32'h0000_0030);
    readChk("R3 clear", 8'h08, 32'h0000_0FC0);
    readChk("R3 clear port reads zero", 8'h0C, 32'h0);
    readChk("R4 fiq mask untouched by irq ports", 8'h28, 32'h0);
    clearAll();
  endtask

  task automatic testFiqEnable();
    busWrite(8'h28, 32'h8000_0001);
    readChk("R4 fiq set", 8'h28, 32'h8000_0001);
    readChk("R4 irq mask untouched", 8'h08, 32'h0);
    busWrite(8'h08, 32'h0000_0006);
    busWrite(8'h2C, 32'h0000_0001);
    readChk("R4 fiq clear", 8'h28, 32'h8000_0000);
    readChk("R4 irq mask after fiq clear", 8'h08, 32'h0000_0006);
    readChk("R4 fiq clear port reads zero", 8'h2C, 32'h0);
    clearAll();
  endtask

  task automatic testRawMasked();
    @(negedge clk);
    srcIn = 32'hA5A5_0003;
    busWrite(8'h10, 32'h0000_0101);
    readChk("R5 raw via 0x04", 8'h04, 32'hA5A5_0103);
    readChk("R5 raw via 0x24", 8'h24, 32'hA5A5_0103);
    busWrite(8'h08, 32'h0000_0102);
    busWrite(8'h28, 32'h00A5_0110);
    readChk("R6 irq masked", 8'h00, 32'h0000_0102);
    readChk("R6 fiq masked", 8'h20, 32'h00A5_0100);
    clearAll();
    readChk("R6 zero when nothing pending", 8'h00, 32'h0);
  endtask

  task automatic testOutputs();
    @(negedge clk);
    srcIn = 32'h0000_0020;
    nextEdge();
    chk("R8 masked source gives no irq", {31'b0, irqOut}, 32'h0);
    busWrite(8'h08, 32'h0000_0020);
    chk("R8 irq not yet on write edge", {31'b0, irqOut}, 32'h0);
    nextEdge();
    chk("R8 irq one edge after enable", {31'b0, irqOut}, 32'h1);
    chk("R8 fiq stays low", {31'b0, fiqOut}, 32'h0);
    repeat (4) nextEdge();
    chk("R9 irq held while level high", {31'b0, irqOut}, 32'h1);
    busWrite(8'h0C, 32'h0000_0020);
    chk("R9 irq still up on mask edge", {31'b0, irqOut}, 32'h1);
    nextEdge();
    chk("R9 irq falls after mask", {31'b0, irqOut}, 32'h0);
    busWrite(8'h08, 32'h0000_0020);
    nextEdge();
    chk("R9 irq back up", {31'b0, irqOut}, 32'h1);
    @(negedge clk);
    srcIn = '0;
    nextEdge();
    chk("R9 irq falls after source drops", {31'b0, irqOut}, 32'h0);
    clearAll();
  endtask

  task automatic testInject();
    busWrite(8'h28, 32'h8000_0000);
    busWrite(8'h10, 32'h8000_0000);
    readChk("R7 latch read", 8'h10, 32'h8000_0000);
    nextEdge();
    chk("R7 injected fiq", {31'b0, fiqOut}, 32'h1);
    chk("R7 irq not enabled", {31'b0, irqOut}, 32'h0);
    busWrite(8'h10, 32'h0000_0004);
    readChk("R7 latch set keeps others", 8'h10, 32'h8000_0004);
    busWrite(8'h14, 32'h8000_0000);
    readChk("R7 latch clear", 8'h10, 32'h0000_0004);
    nextEdge();
    chk("R7 fiq falls after clear", {31'b0, fiqOut}, 32'h0);
    readChk("R7 clear port reads zero", 8'h14, 32'h0);
    clearAll();
  endtask

  task automatic testUnmapped();
    busWrite(8'h08, 32'h0000_0011);
    busWrite(8'h28, 32'h0000_1100);
    busWrite(8'h10, 32'h0000_0001);
    busWrite(8'h00, 32'hFFFF_FFFF);
    busWrite(8'h04, 32'hFFFF_FFFF);
    busWrite(8'h20, 32'hFFFF_FFFF);
    busWrite(8'h24, 32'hFFFF_FFFF);
    busWrite(8'h18, 32'hFFFF_FFFF);
    busWrite(8'h3C, 32'hFFFF_FFFF);
    readChk("R10 irq mask unchanged", 8'h08, 32'h0000_0011);
    readChk("R10 fiq mask unchanged", 8'h28, 32'h0000_1100);
    readChk("R10 latch unchanged", 8'h10, 32'h0000_0001);
    readChk("R10 unmapped 0x18 reads zero", 8'h18, 32'h0);
    readChk("R10 unmapped 0x30 reads zero", 8'h30, 32'h0);
    readChk("R10 unmapped 0xFC reads zero", 8'hFC, 32'h0);
    nextEdge();
    chk("R10 irq from kept state", {31'b0, irqOut}, 32'h1);
    chk("R10 fiq from kept state", {31'b0, fiqOut}, 32'h0);
    clearAll();
  endtask

  initial begin
    addr = '0; wrEn = 1'b0; wrData = '0; srcIn = '0; rstN = 1'b0;
    testReset();
    testIrqEnable();
    testFiqEnable();
    testRawMasked();
    testOutputs();
    testInject();
    testUnmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule